// File: doc/BRIEF.md
# Read-After-Write Interlock for a Five-Stage Pipeline

This block holds back the front end of a five-stage in-order pipeline that has no bypass paths. Each cycle it takes the two source register fields of the instruction in decode and compares them with the destination registers of the three older instructions in the execute, memory and write-back pipeline registers. If any of those older instructions will write a register that decode is about to read, the block freezes the program counter and the fetch/decode register and turns the instruction leaving decode into a no-op. It keeps doing this until the producer has left write-back.

Each downstream stage gives its write-enable bit, a destination-select bit and both of its register fields. The destination is the rd field when the select bit is 1, as for register-to-register operations. It is the rt field when the select bit is 0, as for loads. The register file cannot pass a value through in the cycle it is written, so a match against write-back still stalls. The block is purely combinational. A producer one instruction ahead costs three bubbles, two ahead costs two, and three ahead costs one.

Top module: `hazard_interlock`

## Requirements
- R1: When no enabled downstream stage writes a non-zero register that decode reads, pc_we = 1, ifid_we = 1 and ctrl_zero = 0.
- R2: A stall is raised when the execute stage has ex_wr = 1 and its selected destination is non-zero and equals dec_rs or dec_rt.
- R3: A stall is raised under the same condition for the memory stage (mem_wr, mem_dst_rd, mem_rt, mem_rd).
- R4: A stall is raised under the same condition for the write-back stage, because a same-cycle write is not visible to a read.
- R5: The destination of a stage is its rd field when its select bit is 1 and its rt field when the select bit is 0. The unselected field has no effect on the outputs.
- R6: A stage whose write-enable bit is 0 never causes a stall, whatever its register fields hold.
- R7: Register 0 never causes a stall, even when it is selected, enabled and equal to a source field.
- R8: The outputs always agree: a stall drives pc_we = 0, ifid_we = 0 and ctrl_zero = 1 together, and no stall drives the opposite values.
- R9: Both source fields are compared. A match on dec_rs alone or on dec_rt alone stalls.
- R10: As a producer moves down the pipeline while bubbles fill behind it, a dependent instruction one, two or three slots behind it is stalled for 3, 2 or 1 cycles, and one four slots behind is not stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_rs | input | REG_W | First source register field of the instruction in decode |
| dec_rt | input | REG_W | Second source register field of the instruction in decode |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_dst_rd | input | 1 | Execute-stage destination select: 1 = rd, 0 = rt |
| ex_rt | input | REG_W | Execute-stage rt field |
| ex_rd | input | REG_W | Execute-stage rd field |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_dst_rd | input | 1 | Memory-stage destination select: 1 = rd, 0 = rt |
| mem_rt | input | REG_W | Memory-stage rt field |
| mem_rd | input | REG_W | Memory-stage rd field |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| wb_dst_rd | input | 1 | Write-back-stage destination select: 1 = rd, 0 = rt |
| wb_rt | input | REG_W | Write-back-stage rt field |
| wb_rd | input | REG_W | Write-back-stage rd field |
| pc_we | output | 1 | Program counter may load its next value |
| ifid_we | output | 1 | Fetch/decode pipeline register may load |
| ctrl_zero | output | 1 | Force all control bits leaving decode to zero (bubble) |

## Verification
The assertions hold in every evaluation. They check that the three outputs stay mutually consistent, that a hit reported by any stage comparator always reaches the outputs, and that register 0 or an all-disabled pipeline never produces a stall. The correct choice between the rt and rd fields, and the exact number of bubbles as a producer drains through the stages, can only be shown by the bench. The bench compares the outputs against its own reference function on random stage contents, and it runs a small pipeline model that moves producers at each distance forward until the stall clears.

// File: rtl/hdu_pkg.sv
// Package: shared constants and types for the read-after-write interlock.
// Assumes: three stages downstream of decode, in order execute, memory, write-back.
package hdu_pkg;
    localparam int NUM_STAGES = 3;
    localparam int STG_EX     = 0;
    localparam int STG_MEM    = 1;
    localparam int STG_WB     = 2;

    // Destination-select encoding carried by every downstream stage.
    typedef enum logic {
        DST_RT = 1'b0,
        DST_RD = 1'b1
    } dst_sel_e;
endpackage

// File: rtl/hdu_dest_pick.sv
// Module: picks the register a downstream stage will write, and says whether
// that write can create a dependence.
// Assumes: sel = 1 picks rd, sel = 0 picks rt. When SKIP_ZERO is set,
// register 0 is hard-wired and never counts as a destination.
module hdu_dest_pick #(
    parameter int REG_W     = 5,
    parameter bit SKIP_ZERO = 1'b1
) (
    input  logic             wr_en,
    input  logic             sel_rd,
    input  logic [REG_W-1:0] fld_rt,
    input  logic [REG_W-1:0] fld_rd,
    output logic             dst_valid,
    output logic [REG_W-1:0] dst_idx
);
    import hdu_pkg::*;

    logic nonzero;

    // Choose the written field according to the destination select.
    always_comb begin
        dst_idx = (dst_sel_e'(sel_rd) == DST_RD) ? fld_rd : fld_rt;
    end

    // Pick between the two register-0 policies.
    generate
        if (SKIP_ZERO) begin : g_skip_zero
            assign nonzero = |dst_idx;
        end else begin : g_keep_zero
            assign nonzero = 1'b1;
        end
    endgenerate

    // A destination counts only if the stage really writes it.
    always_comb begin
        dst_valid = wr_en & nonzero;
    end
endmodule

// File: rtl/hdu_src_cmp.sv
// Module: compares both decode source fields against one stage destination.
// Assumes: dst_valid already covers the write enable and the register-0 rule.
module hdu_src_cmp #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic             dst_valid,
    input  logic [REG_W-1:0] dst_idx,
    output logic             hit
);
    logic match_a;
    logic match_b;

    // Equality against each source field.
    always_comb begin
        match_a = (src_a == dst_idx);
        match_b = (src_b == dst_idx);
    end

    // A hit on either source field, qualified by a valid destination.
    always_comb begin
        hit = dst_valid & (match_a | match_b);
    end
endmodule

// File: rtl/hdu_stall_gen.sv
// Module: merges the per-stage hits into the front-end hold and bubble controls.
// Assumes: any single hit is enough to stall; the outputs are combinational.
module hdu_stall_gen #(
    parameter int N = 3
) (
    input  logic [N-1:0] stage_hit,
    output logic         pc_we,
    output logic         ifid_we,
    output logic         ctrl_zero
);
    logic stall;

    // Any stage hit stalls the front end.
    always_comb begin
        stall = |stage_hit;
    end

    // Hold PC and fetch/decode register; zero the decode controls.
    always_comb begin
        pc_we     = ~stall;
        ifid_we   = ~stall;
        ctrl_zero = stall;
    end
endmodule

// File: rtl/hazard_interlock.sv
// Module: read-after-write interlock for a five-stage pipeline with no bypass.
// It compares the decode sources with the execute, memory and write-back
// destinations, and stalls until the producer has left write-back.
// Assumes: the register file does not pass a write through to a same-cycle
// read. Register 0 is hard-wired to zero. The block is fully combinational.
module hazard_interlock #(
    parameter int REG_W     = 5,
    parameter bit SKIP_ZERO = 1'b1
) (
    input  logic [REG_W-1:0] dec_rs,
    input  logic [REG_W-1:0] dec_rt,
    input  logic             ex_wr,
    input  logic             ex_dst_rd,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             mem_wr,
    input  logic             mem_dst_rd,
    input  logic [REG_W-1:0] mem_rt,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             wb_wr,
    input  logic             wb_dst_rd,
    input  logic [REG_W-1:0] wb_rt,
    input  logic [REG_W-1:0] wb_rd,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             ctrl_zero
);
    import hdu_pkg::*;

    localparam int NS = NUM_STAGES;

    logic [NS-1:0]    st_wr;
    logic [NS-1:0]    st_sel;
    logic [REG_W-1:0] st_rt [NS];
    logic [REG_W-1:0] st_rd [NS];
    logic [NS-1:0]    st_dvalid;
    logic [REG_W-1:0] st_didx [NS];
    logic [NS-1:0]    stage_hit;

    // Gather the stage ports into indexed arrays.
    always_comb begin
        st_wr[STG_EX]  = ex_wr;   st_sel[STG_EX]  = ex_dst_rd;
        st_rt[STG_EX]  = ex_rt;   st_rd[STG_EX]   = ex_rd;
        st_wr[STG_MEM] = mem_wr;  st_sel[STG_MEM] = mem_dst_rd;
        st_rt[STG_MEM] = mem_rt;  st_rd[STG_MEM]  = mem_rd;
        st_wr[STG_WB]  = wb_wr;   st_sel[STG_WB]  = wb_dst_rd;
        st_rt[STG_WB]  = wb_rt;   st_rd[STG_WB]   = wb_rd;
    end

    // One destination picker and one comparator per downstream stage.
    generate
        for (genvar s = 0; s < NS; s++) begin : g_stage
            hdu_dest_pick #(.REG_W(REG_W), .SKIP_ZERO(SKIP_ZERO)) u_pick (
                .wr_en     (st_wr[s]),
                .sel_rd    (st_sel[s]),
                .fld_rt    (st_rt[s]),
                .fld_rd    (st_rd[s]),
                .dst_valid (st_dvalid[s]),
                .dst_idx   (st_didx[s])
            );
            hdu_src_cmp #(.REG_W(REG_W)) u_cmp (
                .src_a     (dec_rs),
                .src_b     (dec_rt),
                .dst_valid (st_dvalid[s]),
                .dst_idx   (st_didx[s]),
                .hit       (stage_hit[s])
            );
        end
    endgenerate

    hdu_stall_gen #(.N(NS)) u_stall (
        .stage_hit (stage_hit),
        .pc_we     (pc_we),
        .ifid_we   (ifid_we),
        .ctrl_zero (ctrl_zero)
    );
endmodule

// File: rtl/hazard_interlock_chk.sv
// Module: checker bound to hazard_interlock. Immediate assertions run on every
// settle of the combinational outputs.
// Assumes: stage hits arrive from the comparator instances inside the top.
module hazard_interlock_chk #(
    parameter int REG_W = 5,
    parameter int NS    = 3
) (
    input logic [REG_W-1:0] dec_rs,
    input logic [REG_W-1:0] dec_rt,
    input logic             ex_wr,
    input logic             mem_wr,
    input logic             wb_wr,
    input logic [NS-1:0]    stage_hit,
    input logic             pc_we,
    input logic             ifid_we,
    input logic             ctrl_zero
);
    // Output agreement and per-stage propagation.
    always_comb begin
        assert_outputs_agree_R8: assert ((pc_we == ifid_we) && (ctrl_zero == !pc_we))
            else $error("outputs disagree");
        assert_ex_hit_stalls_R2: assert (!stage_hit[0] || (ctrl_zero && !pc_we))
            else $error("execute hit lost");
        assert_mem_hit_stalls_R3: assert (!stage_hit[1] || (ctrl_zero && !pc_we))
            else $error("memory hit lost");
        assert_wb_hit_stalls_R4: assert (!stage_hit[NS-1] || (ctrl_zero && !ifid_we))
            else $error("write-back hit lost");
        assert_no_hit_runs_R1: assert ((|stage_hit) || (pc_we && ifid_we && !ctrl_zero))
            else $error("stall without a hit");
        assert_zero_reg_free_R7: assert (!((dec_rs == '0) && (dec_rt == '0)) || !ctrl_zero)
            else $error("register 0 stalled");
        assert_disabled_free_R6: assert ((ex_wr || mem_wr || wb_wr) || !ctrl_zero)
            else $error("stall with no writer");
    end
endmodule

bind hazard_interlock hazard_interlock_chk #(.REG_W(REG_W), .NS(NS)) u_chk (
    .dec_rs    (dec_rs),
    .dec_rt    (dec_rt),
    .ex_wr     (ex_wr),
    .mem_wr    (mem_wr),
    .wb_wr     (wb_wr),
    .stage_hit (stage_hit),
    .pc_we     (pc_we),
    .ifid_we   (ifid_we),
    .ctrl_zero (ctrl_zero)
);

// File: tb/hazard_interlock_bench.sv
// Bench: seeded random stage contents checked against a reference function,
// directed corner cases, and a small pipeline model that counts bubbles.
module hazard_interlock_bench;
    localparam int RW = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [RW-1:0] dec_rs, dec_rt;
    logic          wr   [3];
    logic          dsel [3];
    logic [RW-1:0] frt  [3];
    logic [RW-1:0] frd  [3];
    logic          pc_we, ifid_we, ctrl_zero;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    hazard_interlock #(.REG_W(RW)) u_hazard_interlock (
        .dec_rs(dec_rs), .dec_rt(dec_rt),
        .ex_wr(wr[0]),  .ex_dst_rd(dsel[0]),  .ex_rt(frt[0]),  .ex_rd(frd[0]),
        .mem_wr(wr[1]), .mem_dst_rd(dsel[1]), .mem_rt(frt[1]), .mem_rd(frd[1]),
        .wb_wr(wr[2]),  .wb_dst_rd(dsel[2]),  .wb_rt(frt[2]),  .wb_rd(frd[2]),
        .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_zero(ctrl_zero)
    );

    // Reference: does one stage create a dependence on decode?
    function automatic bit ref_hit(int s);
        logic [RW-1:0] d;
        d = dsel[s] ? frd[s] : frt[s];
        return wr[s] && (d != 0) && ((d == dec_rs) || (d == dec_rt));
    endfunction

    function automatic bit ref_stall();
        return ref_hit(0) || ref_hit(1) || ref_hit(2);
    endfunction

    task automatic check_out(string req, bit exp_stall);
        checks++;
        if ({pc_we, ifid_we, ctrl_zero} != {!exp_stall, !exp_stall, exp_stall}) begin
            errors++;
            $display("FAIL %s: got pc_we=%0b ifid_we=%0b ctrl_zero=%0b, expected stall=%0b",
                     req, pc_we, ifid_we, ctrl_zero, exp_stall);
        end
    endtask

    task automatic clear_stages();
        for (int s = 0; s < 3; s++) begin
            wr[s] = 0; dsel[s] = 0; frt[s] = 0; frd[s] = 0;
        end
    endtask

    task automatic settle();
        @(posedge clk); #2;
    endtask

    // Pipeline model: producer writes reg r starting at stage 'start';
    // count stall cycles while it drains and bubbles fill behind it.
    task automatic bubble_run(int start, int exp_bubbles);
        int n;
        clear_stages();
        dec_rs = 5'd9; dec_rt = 5'd3;
        if (start < 3) begin
            wr[start] = 1; dsel[start] = 1; frd[start] = 5'd9; frt[start] = 5'd20;
        end
        n = 0;
        for (int c = 0; c < 6; c++) begin
            settle();
            if (!ctrl_zero) break;
            n++;
            for (int s = 2; s > 0; s--) begin
                wr[s] = wr[s-1]; dsel[s] = dsel[s-1]; frt[s] = frt[s-1]; frd[s] = frd[s-1];
            end
            wr[0] = 0; dsel[0] = 0; frt[0] = 0; frd[0] = 0;
        end
        checks++;
        if (n != exp_bubbles) begin
            errors++;
            $display("FAIL R10: distance %0d got %0d bubbles, expected %0d",
                     start + 1, n, exp_bubbles);
        end
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        dec_rs = 0; dec_rt = 0;
        clear_stages();

        settle();
        check_out("R1 idle", 1'b0);

        // R2/R3/R4 single-stage match through rd.
        for (int s = 0; s < 3; s++) begin
            clear_stages(); dec_rs = 5'd7; dec_rt = 5'd12;
            wr[s] = 1; dsel[s] = 1; frd[s] = 5'd7; frt[s] = 5'd1;
            settle();
            check_out(s == 0 ? "R2 ex" : (s == 1 ? "R3 mem" : "R4 wb"), 1'b1);
        end

        // R5: rt selected (load), rd field holds the matching value but is ignored.
        clear_stages(); dec_rs = 5'd4; dec_rt = 5'd5;
        wr[1] = 1; dsel[1] = 0; frt[1] = 5'd6; frd[1] = 5'd4;
        settle(); check_out("R5 unselected rd", 1'b0);
        frt[1] = 5'd5;
        settle(); check_out("R5 rt selected", 1'b1);

        // R6: write disabled, fields match.
        clear_stages(); dec_rs = 5'd8; dec_rt = 5'd8;
        for (int s = 0; s < 3; s++) begin frd[s] = 5'd8; frt[s] = 5'd8; dsel[s] = 1; end
        settle(); check_out("R6 disabled", 1'b0);

        // R7: register 0 enabled and matching.
        clear_stages(); dec_rs = 0; dec_rt = 5'd2;
        for (int s = 0; s < 3; s++) begin wr[s] = 1; dsel[s] = 1; frd[s] = 0; end
        settle(); check_out("R7 reg zero", 1'b0);

        // R9: match only on dec_rt, then only on dec_rs.
        clear_stages(); dec_rs = 5'd30; dec_rt = 5'd17;
        wr[0] = 1; dsel[0] = 1; frd[0] = 5'd17;
        settle(); check_out("R9 rt only", 1'b1);
        dec_rs = 5'd17; dec_rt = 5'd30;
        settle(); check_out("R9 rs only", 1'b1);

        // R10: bubble counts by distance.
        bubble_run(0, 3);
        bubble_run(1, 2);
        bubble_run(2, 1);
        bubble_run(3, 0);

        // R8 plus R1..R7: random stage contents on a small register range.
        for (int i = 0; i < 400; i++) begin
            dec_rs = RW'($urandom_range(0, 7));
            dec_rt = RW'($urandom_range(0, 7));
            for (int s = 0; s < 3; s++) begin
                wr[s]   = 1'($urandom_range(0, 1));
                dsel[s] = 1'($urandom_range(0, 1));
                frt[s]  = RW'($urandom_range(0, 7));
                frd[s]  = RW'($urandom_range(0, 7));
            end
            settle();
            check_out("R8 random", ref_stall());
        end

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk); cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule